// File: doc/BRIEF.md
# Join-and-Wait Memory Write Sequencer

This block collects two independent arrivals, an address and a data word, each marked by its own valid bit, and issues one memory write strobe once both have been seen. The two may come in either order or in the same cycle. The first value seen for each item is the one written. After the write, the sequencer ignores new arrivals for a number of cycles given by a latency input. This models the time the memory needs to complete the write. It then loops back and waits for the next pair.

A single replay input ends whatever the sequencer is doing, whether it is joining arrivals or waiting out the latency. It discards any partial capture and starts a fresh iteration. The write strobe, address and data outputs are registered. The strobe is high for one cycle, and the address and data outputs keep the last written values between strobes. The memory itself sits outside the block, as does any function that combines the address and data.

Top module: `jw_write_seq`

## Requirements
- R1: Address and data are joined whatever their order, including both in one cycle. `wr_stb` is high for one cycle, in the cycle after the one that presents the completing arrival, and `wr_addr`/`wr_data` carry the captured values.
- R2: Only one strobe is issued per joined pair. A second arrival of an item already captured, before the pair completes, is ignored, and the first value is kept.
- R3: With an effective latency L of 2 or more, arrivals presented in the L-1 cycles that follow the completing cycle are ignored. Arrivals are accepted again from the L-th cycle after it.
- R4: A latency of 1 or 0 (zero counts as one) lets arrivals be accepted in the cycle right after the completing cycle, so strobes can be back to back.
- R5: A replay while the block is joining discards any partly captured address or data.
- R6: A replay during the latency wait ends the wait, and arrivals are accepted from the next cycle.
- R7: No strobe is issued for a cycle in which an accepted replay is presented, even if that cycle would complete a pair. Both items are discarded.
- R8: Replay is ignored in the cycle right after an accepted replay, so a replay held for two cycles restarts only once. Arrivals in that cycle are still captured.
- R9: A synchronous active-high reset clears `wr_stb`, `wr_addr`, `wr_data` and both captures, and leaves the block joining.
- R10: `wr_addr` and `wr_data` change only in a cycle where `wr_stb` is high.
- R11: The latency input is used only in the completing cycle. Changing it during the wait has no effect on that wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_vld | input | 1 | Address arrival marker |
| addr_val | input | ADDR_W | Address payload |
| data_vld | input | 1 | Data arrival marker |
| data_val | input | DATA_W | Data payload |
| lat_cycles | input | LAT_W | Write latency in cycles, unsigned, 0 treated as 1 |
| replay | input | 1 | Restart request |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Address of the current or last write |
| wr_data | output | DATA_W | Data of the current or last write |

## Verification
The join is tried with the address first, the data first, and both in one cycle. These patterns separate a correct join from one that waits for a fixed order or misses the same-cycle case. Repeated arrivals of one item before its partner show whether the first or the last value is kept. Latencies of 0, 1, 2 and 5, with arrivals pushed into every cycle of the wait, locate the exact cycle where acceptance resumes. Replays are placed while joining, while waiting, on the completing cycle, and held for two cycles with a pair in the second cycle, which tells a one-cycle guard apart from a missing one. A long random run is then compared on every clock against a behavioural model.

// File: rtl/jw_pkg.sv
package jw_pkg;
  typedef enum logic [0:0] {
    JW_JOIN = 1'b0,
    JW_WAIT = 1'b1
  } jw_phase_e;
endpackage

// File: rtl/jw_slot.sv
module jw_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         accept,
  input  logic         in_vld,
  input  logic [W-1:0] in_val,
  output logic         held,
  output logic         ready,
  output logic [W-1:0] eff_val
);
  logic [W-1:0] held_val;

  // Ready counts a same-cycle arrival so the join can complete at once.
  assign ready   = held | (accept & in_vld);
  assign eff_val = held ? held_val : in_val;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      held <= 1'b0;
    end else if (accept && in_vld && !held) begin
      held <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_val <= '0;
    end else if (accept && in_vld && !held) begin
      held_val <= in_val;
    end
  end
endmodule

// File: rtl/jw_lat_timer.sv
module jw_lat_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load,
  input  logic [LAT_W-1:0] lat_in,
  output logic             need_wait,
  output logic             last
);
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] lat_eff;

  // Zero latency behaves as one.
  assign lat_eff   = (lat_in == '0) ? LAT_W'(1) : lat_in;
  assign need_wait = (lat_eff > LAT_W'(1));
  assign last      = (cnt <= LAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= lat_eff - LAT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - LAT_W'(1);
    end
  end
endmodule

// File: rtl/jw_ctrl.sv
module jw_ctrl
  import jw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      replay,
  input  logic      a_ready,
  input  logic      d_ready,
  input  logic      need_wait,
  input  logic      last,
  output jw_phase_e phase,
  output logic      guard_q,
  output logic      accept,
  output logic      flush,
  output logic      restart,
  output logic      fire
);
  jw_phase_e phase_nx;

  assign restart = replay & ~guard_q;
  assign accept  = (phase == JW_JOIN) & ~restart;
  assign fire    = accept & a_ready & d_ready;
  assign flush   = restart | fire;

  always_comb begin
    phase_nx = phase;
    if (restart) begin
      phase_nx = JW_JOIN;
    end else begin
      unique case (phase)
        JW_JOIN: if (fire && need_wait) phase_nx = JW_WAIT;
        JW_WAIT: if (last) phase_nx = JW_JOIN;
        default: phase_nx = JW_JOIN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= JW_JOIN;
      guard_q <= 1'b0;
    end else begin
      phase   <= phase_nx;
      guard_q <= restart;
    end
  end
endmodule

// File: rtl/jw_write_seq.sv
module jw_write_seq
  import jw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              data_vld,
  input  logic [DATA_W-1:0] data_val,
  input  logic [LAT_W-1:0]  lat_cycles,
  input  logic              replay,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  jw_phase_e         phase;
  logic              phase_wait;
  logic              guard_q;
  logic              accept, flush, restart, fire;
  logic              a_held, d_held, a_ready, d_ready;
  logic              need_wait, last;
  logic [ADDR_W-1:0] a_eff;
  logic [DATA_W-1:0] d_eff;

  assign phase_wait = (phase == JW_WAIT);

  jw_slot #(.W(ADDR_W)) addr_slot_i (
    .clk(clk), .rst(rst), .flush(flush), .accept(accept),
    .in_vld(addr_vld), .in_val(addr_val),
    .held(a_held), .ready(a_ready), .eff_val(a_eff)
  );

  jw_slot #(.W(DATA_W)) data_slot_i (
    .clk(clk), .rst(rst), .flush(flush), .accept(accept),
    .in_vld(data_vld), .in_val(data_val),
    .held(d_held), .ready(d_ready), .eff_val(d_eff)
  );

  jw_lat_timer #(.LAT_W(LAT_W)) timer_i (
    .clk(clk), .rst(rst), .flush(restart), .load(fire),
    .lat_in(lat_cycles), .need_wait(need_wait), .last(last)
  );

  jw_ctrl ctrl_i (
    .clk(clk), .rst(rst), .replay(replay),
    .a_ready(a_ready), .d_ready(d_ready),
    .need_wait(need_wait), .last(last),
    .phase(phase), .guard_q(guard_q), .accept(accept),
    .flush(flush), .restart(restart), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= fire;
      if (fire) begin
        wr_addr <= a_eff;
        wr_data <= d_eff;
      end
    end
  end
endmodule

// File: rtl/jw_write_seq_chk.sv
module jw_write_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              replay,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              phase_wait,
  input logic              a_held,
  input logic              d_held,
  input logic              guard
);
  // R9: reset leaves the strobe low
  a_r9_reset_quiet: assert property (@(posedge clk) rst |=> !wr_stb);

  // R9: reset leaves both captures empty
  a_r9_reset_empty: assert property (@(posedge clk) rst |=> (!a_held && !d_held));

  // R7: an accepted replay blocks the write
  a_r7_replay_no_write: assert property (@(posedge clk) disable iff (rst)
    (replay && !guard) |=> !wr_stb);

  // R5: an accepted replay discards partial captures
  a_r5_replay_discards: assert property (@(posedge clk) disable iff (rst)
    (replay && !guard) |=> (!a_held && !d_held));

  // R6: an accepted replay ends the latency wait
  a_r6_replay_ends_wait: assert property (@(posedge clk) disable iff (rst)
    (replay && !guard) |=> !phase_wait);

  // R8: the guard cycle only follows a replay
  a_r8_guard_after_replay: assert property (@(posedge clk) disable iff (rst)
    guard |-> $past(replay));

  // R3: no write issued while waiting out the latency
  a_r3_no_write_in_wait: assert property (@(posedge clk) disable iff (rst)
    phase_wait |=> !wr_stb);

  // R3: nothing captured during the wait
  a_r3_no_capture_in_wait: assert property (@(posedge clk) disable iff (rst)
    phase_wait |-> (!a_held && !d_held));

  // R10: write payload holds between strobes
  a_r10_payload_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> ($stable(wr_addr) && $stable(wr_data)));
endmodule

bind jw_write_seq jw_write_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .replay(replay), .wr_stb(wr_stb),
  .wr_addr(wr_addr), .wr_data(wr_data), .phase_wait(phase_wait),
  .a_held(a_held), .d_held(d_held), .guard(guard_q)
);

// File: tb/jw_write_seq_tb_top.sv
module jw_write_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LAT_W  = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              addr_vld;
  logic [ADDR_W-1:0] addr_val;
  logic              data_vld;
  logic [DATA_W-1:0] data_val;
  logic [LAT_W-1:0]  lat_cycles;
  logic              replay;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  int checks = 0;
  int failures = 0;
  int obs_stb = 0;
  bit finished = 1'b0;
  string cur_req = "R9";

  // Behavioural reference state
  bit              m_have_a, m_have_d, m_wait, m_guard;
  int              m_cnt;
  logic [ADDR_W-1:0] m_aval;
  logic [DATA_W-1:0] m_dval;
  bit              e_stb;
  logic [ADDR_W-1:0] e_addr;
  logic [DATA_W-1:0] e_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  jw_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr_val(addr_val),
    .data_vld(data_vld), .data_val(data_val), .lat_cycles(lat_cycles),
    .replay(replay), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step();
    bit rp_eff;
    int le;
    if (rst) begin
      m_have_a = 0; m_have_d = 0; m_wait = 0; m_guard = 0; m_cnt = 0;
      e_stb = 0; e_addr = '0; e_data = '0;
      return;
    end
    rp_eff = replay && !m_guard;
    m_guard = rp_eff;
    e_stb = 0;
    if (rp_eff) begin
      m_have_a = 0; m_have_d = 0; m_wait = 0; m_cnt = 0;
    end else if (!m_wait) begin
      if (addr_vld && !m_have_a) begin m_have_a = 1; m_aval = addr_val; end
      if (data_vld && !m_have_d) begin m_have_d = 1; m_dval = data_val; end
      if (m_have_a && m_have_d) begin
        e_stb = 1; e_addr = m_aval; e_data = m_dval;
        m_have_a = 0; m_have_d = 0;
        le = (lat_cycles == 0) ? 1 : int'(lat_cycles);
        if (le > 1) begin m_wait = 1; m_cnt = le - 1; end
      end
    end else begin
      if (m_cnt <= 1) begin m_wait = 0; m_cnt = 0; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  // Drive one cycle's inputs, advance model, then compare after the edge.
  task automatic tick(input bit av, input logic [ADDR_W-1:0] a, input bit dv,
                      input logic [DATA_W-1:0] d, input int lat, input bit rp);
    addr_vld = av; addr_val = a; data_vld = dv; data_val = d;
    lat_cycles = LAT_W'(lat); replay = rp;
    model_step();
    @(posedge clk);
    @(negedge clk);
    if (wr_stb) obs_stb++;
    check(cur_req, wr_stb == e_stb, longint'(wr_stb), longint'(e_stb));
    check(cur_req, wr_addr == e_addr, longint'(wr_addr), longint'(e_addr));
    check(cur_req, wr_data == e_data, longint'(wr_data), longint'(e_data));
  endtask

  task automatic idle(input int n, input int lat);
    for (int i = 0; i < n; i++) tick(0, '0, 0, '0, lat, 0);
  endtask

  initial begin
    rst = 1; addr_vld = 0; addr_val = '0; data_vld = 0; data_val = '0;
    lat_cycles = '0; replay = 0;
    @(negedge clk);
    // R9: reset state
    cur_req = "R9";
    rst = 1; model_step(); @(posedge clk); @(negedge clk);
    check("R9", wr_stb == 1'b0, longint'(wr_stb), 0);
    check("R9", wr_addr == '0 && wr_data == '0, longint'(wr_addr), 0);
    rst = 0;

    // R1: address first, then data
    cur_req = "R1";
    tick(1, 16'h1111, 0, '0, 1, 0);
    tick(0, '0, 1, 32'hAAAA_0001, 1, 0);
    check("R1", wr_stb && wr_addr == 16'h1111 && wr_data == 32'hAAAA_0001,
          longint'(wr_addr), 64'h1111);
    idle(2, 1);
    // R1: data first
    tick(0, '0, 1, 32'hBBBB_0002, 1, 0);
    idle(2, 1);
    tick(1, 16'h2222, 0, '0, 1, 0);
    idle(1, 1);
    // R1: same cycle
    tick(1, 16'h3333, 1, 32'hCCCC_0003, 1, 0);
    check("R1", wr_stb == 1'b1, longint'(wr_stb), 1);
    idle(2, 1);

    // R2: repeated address keeps the first value, one strobe
    cur_req = "R2";
    obs_stb = 0;
    tick(1, 16'h4444, 0, '0, 1, 0);
    tick(1, 16'h4545, 0, '0, 1, 0);
    tick(1, 16'h4646, 1, 32'hDDDD_0004, 1, 0);
    idle(3, 1);
    check("R2", obs_stb == 1 && wr_addr == 16'h4444, longint'(wr_addr), 64'h4444);

    // R3: latency 5, arrivals pushed into every cycle
    cur_req = "R3";
    tick(1, 16'h5000, 1, 32'h5000_0000, 5, 0);
    for (int i = 1; i <= 6; i++) tick(1, ADDR_W'(16'h5000 + i), 1, DATA_W'(32'h5000_0000 + i), 9, 0);
    idle(10, 2);
    // R3: latency 2
    tick(1, 16'h5200, 1, 32'h5200_0000, 2, 0);
    tick(1, 16'h5201, 1, 32'h5200_0001, 2, 0);
    tick(1, 16'h5202, 1, 32'h5200_0002, 2, 0);
    check("R3", wr_stb && wr_addr == 16'h5202, longint'(wr_addr), 64'h5202);
    idle(3, 1);

    // R11: changing latency during the wait has no effect
    cur_req = "R11";
    tick(1, 16'hB000, 1, 32'hB000_0000, 3, 0);
    tick(1, 16'hB001, 1, 32'hB000_0001, 0, 0);
    tick(1, 16'hB002, 1, 32'hB000_0002, 40, 0);
    tick(1, 16'hB003, 1, 32'hB000_0003, 1, 0);
    check("R11", wr_stb && wr_addr == 16'hB003, longint'(wr_addr), 64'hB003);
    idle(2, 1);

    // R4: latency 1 and 0 allow back-to-back writes
    cur_req = "R4";
    obs_stb = 0;
    for (int i = 0; i < 4; i++) tick(1, ADDR_W'(16'h6000 + i), 1, DATA_W'(i), (i % 2), 0);
    idle(1, 1);
    check("R4", obs_stb == 4, obs_stb, 4);

    // R5: replay discards a partial address
    cur_req = "R5";
    tick(1, 16'h7777, 0, '0, 1, 0);
    tick(0, '0, 0, '0, 1, 1);
    tick(0, '0, 1, 32'h7777_0001, 1, 0);
    idle(2, 1);
    tick(1, 16'h7878, 0, '0, 1, 0);
    idle(1, 1);
    check("R5", wr_addr == 16'h7878, longint'(wr_addr), 64'h7878);

    // R6: replay ends a long latency wait
    cur_req = "R6";
    tick(1, 16'h8000, 1, 32'h8000_0000, 50, 0);
    idle(3, 50);
    tick(0, '0, 0, '0, 50, 1);
    tick(1, 16'h8001, 1, 32'h8000_0001, 1, 0);
    check("R6", wr_stb && wr_addr == 16'h8001, longint'(wr_addr), 64'h8001);
    idle(2, 1);

    // R7: replay on the completing cycle blocks the write
    cur_req = "R7";
    obs_stb = 0;
    tick(1, 16'h9000, 0, '0, 1, 0);
    tick(0, '0, 1, 32'h9000_0001, 1, 1);
    idle(3, 1);
    check("R7", obs_stb == 0, obs_stb, 0);

    // R8: replay held two cycles, pair in the second cycle still writes
    cur_req = "R8";
    obs_stb = 0;
    tick(0, '0, 0, '0, 1, 1);
    tick(1, 16'hA000, 1, 32'hA000_0001, 1, 1);
    idle(1, 1);
    check("R8", obs_stb == 1 && wr_addr == 16'hA000, longint'(wr_addr), 64'hA000);

    // R10 and all: random run against the model
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      tick(($urandom % 3) == 0, ADDR_W'($urandom), ($urandom % 3) == 0,
           DATA_W'($urandom), int'($urandom % 6), ($urandom % 23) == 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog %s: actual=timeout expected=done", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule